// File: doc/BRIEF.md
# Masked Fully Associative Translation Buffer

This block caches a small set of virtual-to-physical page mappings and searches all of them in parallel. Each slot stores a virtual page number, a per-slot ignore mask that lets one slot cover a larger page, an address-space tag, a global flag, two valid bits and two physical frame numbers. A lookup presents a virtual address, an address-space tag and an access kind. One clock later the block returns whether a slot matched, which slot it was, and that slot's frame fields. It also flags an address in the uncached window and an instruction fetch that is not word aligned. These flags are separate from the match result and do not depend on it.

Software-style maintenance goes through the same block. An indexed write loads or replaces a whole slot. A flush-all clears the table. A round-robin victim pointer shows the slot it currently names and can step to the next slot on request. Four saturating counters record read and write hits and misses, and the block also gives their sums.

Top module: `tlb_assoc_masked`

## Requirements
- R1: A slot matches a lookup only when the lookup page number (address bits above the page offset) equals the slot's page number in every bit where the slot's mask bit is 0. Bits where the mask bit is 1 are ignored.
- R2: A page-number match counts only if the slot's global flag is 1 or the lookup tag equals the slot's stored tag.
- R3: On a hit, `rs_idx` carries the slot number with its top bit 0. On a miss, `rs_idx` is all ones (-1), `rs_hit` is 0 and all frame and valid result fields are 0.
- R4: A slot takes part in matching only when at least one of its two valid bits is 1.
- R5: A write whose `wr_idx` is NUM_ENTRIES or larger leaves every slot unchanged.
- R6: A write to an occupied slot replaces it completely, so the old page number stops hitting in that slot.
- R7: `flush` clears every slot, including both valid bits, and sets the victim pointer to 0. Flush wins over a write in the same cycle.
- R8: `rs_uncached` is 1 exactly when the looked-up address ANDed with 0xA0000000 equals 0xA0000000.
- R9: `rs_misalign` is 1 exactly when the access kind is fetch (`lk_kind` = 2'b10) and address bit 1 or bit 0 is 1. Kind 2'b00 is read, 2'b01 is write, and 2'b11 is treated as read.
- R10: The `vic_*` outputs show the slot at the victim pointer. With `vic_rd` and `vic_adv` both 1, the pointer steps by one and wraps from NUM_ENTRIES-1 to 0. Otherwise it holds.
- R11: When several slots match, the lowest slot number wins.
- R12: `rs_valid` and the result fields update at the first rising edge after `lk_valid` is sampled 1. The table contents used are those from before any write in that same cycle.
- R13: Read lookups (read, fetch and kind 2'b11) add to the read-hit or read-miss counter, and write lookups add to the write-hit or write-miss counter. Each counter stops at 2^CNT_W-1. The totals are read plus write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | VA_W | Lookup virtual address |
| lk_asid | input | ASID_W | Lookup address-space tag |
| lk_kind | input | 2 | Access kind: 00 read, 01 write, 10 fetch, 11 read |
| rs_valid | output | 1 | Lookup result valid |
| rs_hit | output | 1 | A slot matched |
| rs_idx | output | IDX_W+1 | Matching slot, all ones on miss |
| rs_pfn0 | output | PFN_W | Matched slot first frame |
| rs_pfn1 | output | PFN_W | Matched slot second frame |
| rs_v0 | output | 1 | Matched slot first valid bit |
| rs_v1 | output | 1 | Matched slot second valid bit |
| rs_uncached | output | 1 | Address lies in the uncached window |
| rs_misalign | output | 1 | Fetch not word aligned |
| wr_en | input | 1 | Indexed slot write |
| wr_idx | input | IDX_W+1 | Slot to write |
| wr_vpn | input | VPN_W | New page number |
| wr_mask | input | VPN_W | New ignore mask |
| wr_asid | input | ASID_W | New tag |
| wr_glob | input | 1 | New global flag |
| wr_v0 | input | 1 | New first valid bit |
| wr_v1 | input | 1 | New second valid bit |
| wr_pfn0 | input | PFN_W | New first frame |
| wr_pfn1 | input | PFN_W | New second frame |
| flush | input | 1 | Clear whole table and victim pointer |
| vic_rd | input | 1 | Victim read strobe |
| vic_adv | input | 1 | Step pointer with this read |
| vic_ptr | output | IDX_W | Victim pointer |
| vic_vpn | output | VPN_W | Page number of victim slot |
| vic_pfn0 | output | PFN_W | First frame of victim slot |
| vic_present | output | 1 | Victim slot has a valid bit set |
| cnt_rd_hit | output | CNT_W | Read hits |
| cnt_rd_miss | output | CNT_W | Read misses |
| cnt_wr_hit | output | CNT_W | Write hits |
| cnt_wr_miss | output | CNT_W | Write misses |
| tot_hit | output | CNT_W+1 | Sum of hits |
| tot_miss | output | CNT_W+1 | Sum of misses |
| tot_acc | output | CNT_W+2 | Sum of all lookups |

## Verification
The hardest case to reach from the ports is two occupied slots that both match one lookup, where the winner changes with the lookup tag. To build it, the bench first loads a global slot at a higher index and then a tagged slot at a lower index. A lookup with the matching tag must return the lower slot, and a lookup with any other tag must fall through to the global one. Counter saturation is reached by building the bench with a narrow counter width and issuing a long run of misses. The victim pointer is stepped through a full lap to check the wrap.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
   parameter int VA_W       = 32;
   parameter int PAGE_SHIFT = 12;
   parameter int VPN_W      = VA_W - PAGE_SHIFT;
   parameter int ASID_W     = 8;
   parameter int PFN_W      = 20;

   // uncached window pattern: all its set bits must be present in the address
   localparam logic [VA_W-1:0] UNCACHED_PAT = 32'hA000_0000;

   typedef enum logic [1:0] {
      ACC_READ  = 2'b00,
      ACC_WRITE = 2'b01,
      ACC_FETCH = 2'b10,
      ACC_RSVD  = 2'b11
   } acc_kind_e;

   typedef struct packed {
      logic [VPN_W-1:0]  vpn;
      logic [VPN_W-1:0]  mask;
      logic [ASID_W-1:0] asid;
      logic              glob;
      logic              v0;
      logic              v1;
      logic [PFN_W-1:0]  pfn0;
      logic [PFN_W-1:0]  pfn1;
   } tlb_entry_t;
endpackage

// File: rtl/tlb_match_cell.sv
module tlb_match_cell
   import tlb_pkg::*;
(
   input  tlb_entry_t        ent,
   input  logic [VPN_W-1:0]  vpn,
   input  logic [ASID_W-1:0] asid,
   output logic              hit
);
   logic present;
   logic vpn_eq;
   logic owner_ok;

   assign present  = ent.v0 | ent.v1;
   assign vpn_eq   = ((vpn ^ ent.vpn) & ~ent.mask) == '0;
   assign owner_ok = ent.glob | (asid == ent.asid);
   assign hit      = present & vpn_eq & owner_ok;
endmodule

// File: rtl/tlb_first_hit.sv
module tlb_first_hit #(
   parameter int NUM_ENTRIES = 8,
   parameter int IDX_W       = 3
) (
   input  logic [NUM_ENTRIES-1:0] hits,
   output logic                   any,
   output logic [IDX_W-1:0]       idx
);
   always_comb begin
      any = |hits;
      idx = '0;
      for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
         if (hits[i]) idx = IDX_W'(i);
      end
   end
endmodule

// File: rtl/tlb_victim_ptr.sv
module tlb_victim_ptr #(
   parameter int NUM_ENTRIES = 8,
   parameter int IDX_W       = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             step,
   output logic [IDX_W-1:0] ptr
);
   localparam bit POW2 = (NUM_ENTRIES == (1 << IDX_W));
   logic [IDX_W-1:0] nxt;

   generate
      if (POW2) begin : g_natural_wrap
         assign nxt = ptr + 1'b1;
      end else begin : g_compare_wrap
         assign nxt = (ptr == IDX_W'(NUM_ENTRIES - 1)) ? '0 : ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ptr <= '0;
      else if (clear) ptr <= '0;
      else if (step)  ptr <= nxt;
   end
endmodule

// File: rtl/tlb_sat_counter.sv
module tlb_sat_counter #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   output logic [W-1:0] cnt
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt <= '0;
      else if (inc && !(&cnt))   cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/tlb_assoc_masked.sv
module tlb_assoc_masked
   import tlb_pkg::*;
#(
   parameter int NUM_ENTRIES = 8,
   parameter int CNT_W       = 16,
   localparam int IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1,
   localparam int WIDX_W     = IDX_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lk_valid,
   input  logic [VA_W-1:0]   lk_va,
   input  logic [ASID_W-1:0] lk_asid,
   input  logic [1:0]        lk_kind,
   output logic              rs_valid,
   output logic              rs_hit,
   output logic [WIDX_W-1:0] rs_idx,
   output logic [PFN_W-1:0]  rs_pfn0,
   output logic [PFN_W-1:0]  rs_pfn1,
   output logic              rs_v0,
   output logic              rs_v1,
   output logic              rs_uncached,
   output logic              rs_misalign,
   input  logic              wr_en,
   input  logic [WIDX_W-1:0] wr_idx,
   input  logic [VPN_W-1:0]  wr_vpn,
   input  logic [VPN_W-1:0]  wr_mask,
   input  logic [ASID_W-1:0] wr_asid,
   input  logic              wr_glob,
   input  logic              wr_v0,
   input  logic              wr_v1,
   input  logic [PFN_W-1:0]  wr_pfn0,
   input  logic [PFN_W-1:0]  wr_pfn1,
   input  logic              flush,
   input  logic              vic_rd,
   input  logic              vic_adv,
   output logic [IDX_W-1:0]  vic_ptr,
   output logic [VPN_W-1:0]  vic_vpn,
   output logic [PFN_W-1:0]  vic_pfn0,
   output logic              vic_present,
   output logic [CNT_W-1:0]  cnt_rd_hit,
   output logic [CNT_W-1:0]  cnt_rd_miss,
   output logic [CNT_W-1:0]  cnt_wr_hit,
   output logic [CNT_W-1:0]  cnt_wr_miss,
   output logic [CNT_W:0]    tot_hit,
   output logic [CNT_W:0]    tot_miss,
   output logic [CNT_W+1:0]  tot_acc
);
   localparam int NUM_CNT   = 4;
   localparam int C_RD_HIT  = 0;
   localparam int C_RD_MISS = 1;
   localparam int C_WR_HIT  = 2;
   localparam int C_WR_MISS = 3;

   // elaboration-time parameter checks
   generate
      if (NUM_ENTRIES < 2) begin : g_bad_entries
         $error("tlb_assoc_masked: NUM_ENTRIES must be at least 2");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("tlb_assoc_masked: CNT_W must be at least 1");
      end
      if (PAGE_SHIFT < 2) begin : g_bad_page
         $error("tlb_assoc_masked: PAGE_SHIFT must keep the two low address bits in the offset");
      end
   endgenerate

   // slot storage
   tlb_entry_t table_q [NUM_ENTRIES];
   tlb_entry_t wr_ent;
   logic       wr_in_range;

   assign wr_in_range = (wr_idx < WIDX_W'(NUM_ENTRIES));

   always_comb begin
      wr_ent.vpn  = wr_vpn;
      wr_ent.mask = wr_mask;
      wr_ent.asid = wr_asid;
      wr_ent.glob = wr_glob;
      wr_ent.v0   = wr_v0;
      wr_ent.v1   = wr_v1;
      wr_ent.pfn0 = wr_pfn0;
      wr_ent.pfn1 = wr_pfn1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_ENTRIES; i++) table_q[i] <= '0;
      end else if (flush) begin
         for (int i = 0; i < NUM_ENTRIES; i++) table_q[i] <= '0;
      end else if (wr_en && wr_in_range) begin
         table_q[wr_idx[IDX_W-1:0]] <= wr_ent;
      end
   end

   // parallel compare
   logic [VPN_W-1:0]       lk_vpn;
   logic [NUM_ENTRIES-1:0] hit_vec;
   logic                   any_hit;
   logic [IDX_W-1:0]       hit_idx;
   tlb_entry_t             hit_ent;

   assign lk_vpn = lk_va[VA_W-1:PAGE_SHIFT];

   generate
      for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_cell
         tlb_match_cell u_cell (
            .ent  (table_q[g]),
            .vpn  (lk_vpn),
            .asid (lk_asid),
            .hit  (hit_vec[g])
         );
      end
   endgenerate

   tlb_first_hit #(
      .NUM_ENTRIES (NUM_ENTRIES),
      .IDX_W       (IDX_W)
   ) u_first (
      .hits (hit_vec),
      .any  (any_hit),
      .idx  (hit_idx)
   );

   assign hit_ent = table_q[hit_idx];

   // side flags
   logic is_write;
   logic uncached_d;
   logic misalign_d;

   assign is_write   = (lk_kind == ACC_WRITE);
   assign uncached_d = (lk_va & UNCACHED_PAT) == UNCACHED_PAT;
   assign misalign_d = (lk_kind == ACC_FETCH) && (lk_va[1:0] != 2'b00);

   // registered result
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rs_valid    <= 1'b0;
         rs_hit      <= 1'b0;
         rs_idx      <= '1;
         rs_pfn0     <= '0;
         rs_pfn1     <= '0;
         rs_v0       <= 1'b0;
         rs_v1       <= 1'b0;
         rs_uncached <= 1'b0;
         rs_misalign <= 1'b0;
      end else begin
         rs_valid <= lk_valid;
         if (lk_valid) begin
            rs_hit      <= any_hit;
            rs_idx      <= any_hit ? {1'b0, hit_idx} : '1;
            rs_pfn0     <= any_hit ? hit_ent.pfn0 : '0;
            rs_pfn1     <= any_hit ? hit_ent.pfn1 : '0;
            rs_v0       <= any_hit & hit_ent.v0;
            rs_v1       <= any_hit & hit_ent.v1;
            rs_uncached <= uncached_d;
            rs_misalign <= misalign_d;
         end
      end
   end

   // victim pointer
   tlb_entry_t vic_ent;

   tlb_victim_ptr #(
      .NUM_ENTRIES (NUM_ENTRIES),
      .IDX_W       (IDX_W)
   ) u_vic (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (flush),
      .step  (vic_rd & vic_adv),
      .ptr   (vic_ptr)
   );

   assign vic_ent     = table_q[vic_ptr];
   assign vic_vpn     = vic_ent.vpn;
   assign vic_pfn0    = vic_ent.pfn0;
   assign vic_present = vic_ent.v0 | vic_ent.v1;

   // event counters
   logic [NUM_CNT-1:0] cnt_inc;
   logic [CNT_W-1:0]   cnt_val [NUM_CNT];

   assign cnt_inc[C_RD_HIT]  = lk_valid & ~is_write &  any_hit;
   assign cnt_inc[C_RD_MISS] = lk_valid & ~is_write & ~any_hit;
   assign cnt_inc[C_WR_HIT]  = lk_valid &  is_write &  any_hit;
   assign cnt_inc[C_WR_MISS] = lk_valid &  is_write & ~any_hit;

   generate
      for (genvar c = 0; c < NUM_CNT; c++) begin : g_cnt
         tlb_sat_counter #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (cnt_inc[c]),
            .cnt   (cnt_val[c])
         );
      end
   endgenerate

   assign cnt_rd_hit  = cnt_val[C_RD_HIT];
   assign cnt_rd_miss = cnt_val[C_RD_MISS];
   assign cnt_wr_hit  = cnt_val[C_WR_HIT];
   assign cnt_wr_miss = cnt_val[C_WR_MISS];
   assign tot_hit     = {1'b0, cnt_rd_hit}  + {1'b0, cnt_wr_hit};
   assign tot_miss    = {1'b0, cnt_rd_miss} + {1'b0, cnt_wr_miss};
   assign tot_acc     = {1'b0, tot_hit} + {1'b0, tot_miss};
endmodule

// File: rtl/tlb_assoc_masked_chk.sv
module tlb_assoc_masked_chk
   import tlb_pkg::*;
#(
   parameter int NUM_ENTRIES = 8,
   parameter int CNT_W       = 16,
   localparam int IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1,
   localparam int WIDX_W     = IDX_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lk_valid,
   input  logic [VA_W-1:0]   lk_va,
   input  logic [1:0]        lk_kind,
   input  logic              rs_valid,
   input  logic              rs_hit,
   input  logic [WIDX_W-1:0] rs_idx,
   input  logic [PFN_W-1:0]  rs_pfn0,
   input  logic              rs_v0,
   input  logic              rs_v1,
   input  logic              rs_uncached,
   input  logic              rs_misalign,
   input  logic              flush,
   input  logic              vic_rd,
   input  logic              vic_adv,
   input  logic [IDX_W-1:0]  vic_ptr,
   input  logic [CNT_W-1:0]  cnt_rd_hit,
   input  logic [CNT_W-1:0]  cnt_rd_miss
);
   logic armed;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   assert_result_latency_R12: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> (rs_valid == $past(lk_valid)));

   assert_miss_index_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rs_valid && !rs_hit) |-> (&rs_idx));

   assert_miss_payload_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rs_valid && !rs_hit) |-> (rs_pfn0 == '0 && !rs_v0 && !rs_v1));

   assert_hit_index_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rs_valid && rs_hit) |-> (int'(rs_idx) < NUM_ENTRIES));

   assert_hit_present_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rs_valid && rs_hit) |-> (rs_v0 || rs_v1));

   assert_uncached_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && rs_valid) |->
         (rs_uncached == (($past(lk_va) & UNCACHED_PAT) == UNCACHED_PAT)));

   assert_misalign_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && rs_valid) |->
         (rs_misalign == ($past(lk_kind) == 2'b10 && $past(lk_va[1:0]) != 2'b00)));

   assert_flush_ptr_R7: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (vic_ptr == '0));

   assert_ptr_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (vic_rd && vic_adv && !flush) |=>
         (vic_ptr == (($past(vic_ptr) == IDX_W'(NUM_ENTRIES - 1)) ? '0 : $past(vic_ptr) + 1'b1)));

   assert_ptr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!(vic_rd && vic_adv) && !flush) |=> $stable(vic_ptr));

   assert_rd_hit_sat_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (&cnt_rd_hit) |=> (&cnt_rd_hit));

   assert_rd_miss_sat_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (&cnt_rd_miss) |=> (&cnt_rd_miss));
endmodule

bind tlb_assoc_masked tlb_assoc_masked_chk #(
   .NUM_ENTRIES (NUM_ENTRIES),
   .CNT_W       (CNT_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .lk_valid    (lk_valid),
   .lk_va       (lk_va),
   .lk_kind     (lk_kind),
   .rs_valid    (rs_valid),
   .rs_hit      (rs_hit),
   .rs_idx      (rs_idx),
   .rs_pfn0     (rs_pfn0),
   .rs_v0       (rs_v0),
   .rs_v1       (rs_v1),
   .rs_uncached (rs_uncached),
   .rs_misalign (rs_misalign),
   .flush       (flush),
   .vic_rd      (vic_rd),
   .vic_adv     (vic_adv),
   .vic_ptr     (vic_ptr),
   .cnt_rd_hit  (cnt_rd_hit),
   .cnt_rd_miss (cnt_rd_miss)
);

// File: tb/tb_tlb_assoc_masked.sv
module tb_tlb_assoc_masked;
   import tlb_pkg::*;

   localparam int CLK_PERIOD = 10;
   localparam int N          = 8;
   localparam int CW         = 4;
   localparam int CMAX       = (1 << CW) - 1;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              lk_valid = 1'b0;
   logic [VA_W-1:0]   lk_va = '0;
   logic [ASID_W-1:0] lk_asid = '0;
   logic [1:0]        lk_kind = 2'b00;
   logic              rs_valid, rs_hit, rs_v0, rs_v1, rs_uncached, rs_misalign;
   logic [3:0]        rs_idx;
   logic [PFN_W-1:0]  rs_pfn0, rs_pfn1;
   logic              wr_en = 1'b0;
   logic [3:0]        wr_idx = '0;
   logic [VPN_W-1:0]  wr_vpn = '0, wr_mask = '0;
   logic [ASID_W-1:0] wr_asid = '0;
   logic              wr_glob = 1'b0, wr_v0 = 1'b0, wr_v1 = 1'b0;
   logic [PFN_W-1:0]  wr_pfn0 = '0, wr_pfn1 = '0;
   logic              flush = 1'b0, vic_rd = 1'b0, vic_adv = 1'b0;
   logic [2:0]        vic_ptr;
   logic [VPN_W-1:0]  vic_vpn;
   logic [PFN_W-1:0]  vic_pfn0;
   logic              vic_present;
   logic [CW-1:0]     cnt_rd_hit, cnt_rd_miss, cnt_wr_hit, cnt_wr_miss;
   logic [CW:0]       tot_hit, tot_miss;
   logic [CW+1:0]     tot_acc;

   tlb_assoc_masked #(.NUM_ENTRIES(N), .CNT_W(CW)) dut (
      .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_va(lk_va), .lk_asid(lk_asid),
      .lk_kind(lk_kind), .rs_valid(rs_valid), .rs_hit(rs_hit), .rs_idx(rs_idx),
      .rs_pfn0(rs_pfn0), .rs_pfn1(rs_pfn1), .rs_v0(rs_v0), .rs_v1(rs_v1),
      .rs_uncached(rs_uncached), .rs_misalign(rs_misalign), .wr_en(wr_en),
      .wr_idx(wr_idx), .wr_vpn(wr_vpn), .wr_mask(wr_mask), .wr_asid(wr_asid),
      .wr_glob(wr_glob), .wr_v0(wr_v0), .wr_v1(wr_v1), .wr_pfn0(wr_pfn0),
      .wr_pfn1(wr_pfn1), .flush(flush), .vic_rd(vic_rd), .vic_adv(vic_adv),
      .vic_ptr(vic_ptr), .vic_vpn(vic_vpn), .vic_pfn0(vic_pfn0),
      .vic_present(vic_present), .cnt_rd_hit(cnt_rd_hit), .cnt_rd_miss(cnt_rd_miss),
      .cnt_wr_hit(cnt_wr_hit), .cnt_wr_miss(cnt_wr_miss), .tot_hit(tot_hit),
      .tot_miss(tot_miss), .tot_acc(tot_acc)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // reference model built from the requirements
   logic [VPN_W-1:0]  m_vpn  [N];
   logic [VPN_W-1:0]  m_mask [N];
   logic [ASID_W-1:0] m_asid [N];
   bit                m_glob [N];
   bit                m_v0   [N];
   bit                m_v1   [N];
   logic [PFN_W-1:0]  m_pfn0 [N];
   logic [PFN_W-1:0]  m_pfn1 [N];
   int m_ptr = 0;
   int m_rh = 0, m_rm = 0, m_wh = 0, m_wm = 0;

   typedef struct {
      bit               hit;
      logic [3:0]       idx;
      logic [PFN_W-1:0] pfn0;
      logic [PFN_W-1:0] pfn1;
      bit               v0;
      bit               v1;
      bit               unc;
      bit               mis;
      string            req;
   } exp_t;

   exp_t sb[$];

   function automatic int sat_inc(input int v);
      return (v < CMAX) ? v + 1 : v;
   endfunction

   task automatic model_clear();
      for (int i = 0; i < N; i++) begin
         m_vpn[i] = '0; m_mask[i] = '0; m_asid[i] = '0; m_glob[i] = 0;
         m_v0[i] = 0; m_v1[i] = 0; m_pfn0[i] = '0; m_pfn1[i] = '0;
      end
      m_ptr = 0;
   endtask

   // driver: one lookup, expectation pushed to the scoreboard
   task automatic lookup(input logic [VPN_W-1:0] vpn, input logic [11:0] off,
                         input logic [ASID_W-1:0] asid, input logic [1:0] kind,
                         input string req);
      exp_t e;
      logic [VA_W-1:0] va;
      int found;
      va = {vpn, off};
      found = -1;
      for (int i = N - 1; i >= 0; i--) begin
         if ((m_v0[i] || m_v1[i]) && (((vpn ^ m_vpn[i]) & ~m_mask[i]) == '0)
             && (m_glob[i] || asid == m_asid[i]))
            found = i;
      end
      e.hit  = (found >= 0);
      e.idx  = e.hit ? 4'(found) : 4'hF;
      e.pfn0 = e.hit ? m_pfn0[found] : '0;
      e.pfn1 = e.hit ? m_pfn1[found] : '0;
      e.v0   = e.hit ? m_v0[found] : 0;
      e.v1   = e.hit ? m_v1[found] : 0;
      e.unc  = ((va & 32'hA000_0000) == 32'hA000_0000);
      e.mis  = (kind == 2'b10) && (va[1:0] != 2'b00);
      e.req  = req;
      if (kind == 2'b01) begin
         if (e.hit) m_wh = sat_inc(m_wh); else m_wm = sat_inc(m_wm);
      end else begin
         if (e.hit) m_rh = sat_inc(m_rh); else m_rm = sat_inc(m_rm);
      end
      @(negedge clk);
      lk_valid = 1'b1; lk_va = va; lk_asid = asid; lk_kind = kind;
      sb.push_back(e);
      @(negedge clk);
      lk_valid = 1'b0;
   endtask

   // monitor: pops one expectation per result
   always @(negedge clk) begin
      if (rst_n && rs_valid) begin
         if (sb.size() == 0) begin
            chk(1'b0, "R12", "unexpected result", 1, 0);
         end else begin
            exp_t e;
            e = sb.pop_front();
            chk(rs_hit == e.hit, e.req, "hit", rs_hit, e.hit);
            chk(rs_idx == e.idx, e.req, "index", rs_idx, e.idx);
            chk(rs_pfn0 == e.pfn0 && rs_pfn1 == e.pfn1, e.req, "frames",
                {rs_pfn0, rs_pfn1}, {e.pfn0, e.pfn1});
            chk(rs_v0 == e.v0 && rs_v1 == e.v1, e.req, "valid bits",
                {rs_v0, rs_v1}, {e.v0, e.v1});
            chk(rs_uncached == e.unc, "R8", "uncached", rs_uncached, e.unc);
            chk(rs_misalign == e.mis, "R9", "misalign", rs_misalign, e.mis);
         end
      end
   end

   task automatic write_slot(input logic [3:0] idx, input logic [VPN_W-1:0] vpn,
                             input logic [VPN_W-1:0] mask, input logic [ASID_W-1:0] asid,
                             input bit glob, input bit v0, input bit v1,
                             input logic [PFN_W-1:0] p0, input logic [PFN_W-1:0] p1);
      @(negedge clk);
      wr_en = 1'b1; wr_idx = idx; wr_vpn = vpn; wr_mask = mask; wr_asid = asid;
      wr_glob = glob; wr_v0 = v0; wr_v1 = v1; wr_pfn0 = p0; wr_pfn1 = p1;
      @(negedge clk);
      wr_en = 1'b0;
      if (idx < N) begin
         m_vpn[idx] = vpn; m_mask[idx] = mask; m_asid[idx] = asid; m_glob[idx] = glob;
         m_v0[idx] = v0; m_v1[idx] = v1; m_pfn0[idx] = p0; m_pfn1[idx] = p1;
      end
   endtask

   task automatic do_flush();
      @(negedge clk);
      flush = 1'b1;
      @(negedge clk);
      flush = 1'b0;
      model_clear();
   endtask

   task automatic victim(input bit adv);
      @(negedge clk);
      vic_rd = 1'b1; vic_adv = adv;
      #1;
      chk(vic_ptr == 3'(m_ptr), "R10", "victim pointer", vic_ptr, m_ptr);
      chk(vic_vpn == m_vpn[m_ptr] && vic_pfn0 == m_pfn0[m_ptr], "R10", "victim slot",
          vic_vpn, m_vpn[m_ptr]);
      chk(vic_present == (m_v0[m_ptr] || m_v1[m_ptr]), "R10", "victim present",
          vic_present, m_v0[m_ptr] || m_v1[m_ptr]);
      @(negedge clk);
      vic_rd = 1'b0; vic_adv = 1'b0;
      if (adv) m_ptr = (m_ptr + 1) % N;
   endtask

   task automatic check_counters(input string tag);
      chk(cnt_rd_hit == CW'(m_rh) && cnt_rd_miss == CW'(m_rm), "R13", {tag, " read counters"},
          {cnt_rd_hit, cnt_rd_miss}, {CW'(m_rh), CW'(m_rm)});
      chk(cnt_wr_hit == CW'(m_wh) && cnt_wr_miss == CW'(m_wm), "R13", {tag, " write counters"},
          {cnt_wr_hit, cnt_wr_miss}, {CW'(m_wh), CW'(m_wm)});
      chk(int'(tot_hit) == m_rh + m_wh && int'(tot_miss) == m_rm + m_wm
          && int'(tot_acc) == m_rh + m_wh + m_rm + m_wm, "R13", {tag, " totals"},
          tot_acc, m_rh + m_wh + m_rm + m_wm);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         chk(1'b0, "watchdog", "run did not finish", 0, 1);
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      model_clear();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state
      chk(rs_valid == 1'b0, "R12", "reset result valid", rs_valid, 0);
      chk(vic_ptr == '0 && vic_present == 1'b0, "R7", "reset victim", vic_ptr, 0);
      check_counters("reset");

      // R2: tag-private slot
      write_slot(4'd0, 20'h12345, 20'h0, 8'h05, 0, 1, 1, 20'hA0A0A, 20'hB0B0B);
      lookup(20'h12345, 12'h010, 8'h05, 2'b00, "R2 tag match");
      lookup(20'h12345, 12'h010, 8'h06, 2'b00, "R2 tag mismatch");
      // R1: masked large page, global
      write_slot(4'd1, 20'h40000, 20'h000FF, 8'h00, 1, 1, 0, 20'h11111, 20'h22222);
      lookup(20'h400AB, 12'h000, 8'h77, 2'b01, "R1 masked bits ignored");
      lookup(20'h401AB, 12'h000, 8'h77, 2'b01, "R1 unmasked bit differs");
      // R11: two matches, lower index wins
      write_slot(4'd3, 20'h77700, 20'h0, 8'h00, 1, 1, 1, 20'h33333, 20'h33334);
      write_slot(4'd2, 20'h77700, 20'h0, 8'h05, 0, 0, 1, 20'h22220, 20'h22221);
      lookup(20'h77700, 12'h000, 8'h05, 2'b00, "R11 lowest wins");
      lookup(20'h77700, 12'h000, 8'h09, 2'b00, "R11 global fallback");
      // R4: presence
      write_slot(4'd4, 20'h55555, 20'h0, 8'h00, 1, 0, 0, 20'h44444, 20'h44444);
      write_slot(4'd5, 20'h66666, 20'h0, 8'h00, 1, 0, 1, 20'h50505, 20'h60606);
      lookup(20'h55555, 12'h000, 8'h00, 2'b00, "R4 no valid bit");
      lookup(20'h66666, 12'h000, 8'h00, 2'b01, "R4 one valid bit");
      // R5: out-of-range writes ignored
      write_slot(4'd8, 20'h12345, 20'h0, 8'h05, 1, 1, 1, 20'hDEAD0, 20'hDEAD1);
      write_slot(4'd15, 20'h99999, 20'h0, 8'h05, 1, 1, 1, 20'hBEEF0, 20'hBEEF1);
      lookup(20'h12345, 12'h000, 8'h05, 2'b00, "R5 slot 0 unchanged");
      lookup(20'h99999, 12'h000, 8'h05, 2'b00, "R5 no new mapping");
      // R6: overwrite
      write_slot(4'd0, 20'h2468A, 20'h0, 8'h05, 0, 1, 0, 20'hCCCCC, 20'hDDDDD);
      lookup(20'h12345, 12'h000, 8'h05, 2'b00, "R6 old page gone");
      lookup(20'h2468A, 12'h000, 8'h05, 2'b00, "R6 new page hits");
      // R8 / R9 flags, hit or miss
      lookup(20'hE0000, 12'h000, 8'h00, 2'b00, "R8 window E");
      lookup(20'hA0000, 12'h004, 8'h00, 2'b10, "R8 window A");
      lookup(20'h80000, 12'h000, 8'h00, 2'b00, "R8 bit 29 clear");
      lookup(20'h20000, 12'h000, 8'h00, 2'b00, "R8 bit 31 clear");
      lookup(20'h2468A, 12'h002, 8'h05, 2'b10, "R9 fetch misaligned");
      lookup(20'h2468A, 12'h001, 8'h05, 2'b10, "R9 fetch low bit");
      lookup(20'h2468A, 12'h003, 8'h05, 2'b00, "R9 read not flagged");
      lookup(20'h2468A, 12'h008, 8'h05, 2'b11, "R9 kind 11 as read");
      // R12: back-to-back results in order
      lookup(20'h400CD, 12'h000, 8'h01, 2'b00, "R12 sequence a");
      lookup(20'h66666, 12'h000, 8'h01, 2'b00, "R12 sequence b");
      @(negedge clk);
      check_counters("mid");
      // R10: victim pointer
      victim(0);
      victim(0);
      for (int k = 0; k < N + 2; k++) victim(1);
      // R7: flush
      victim(1);
      do_flush();
      chk(vic_ptr == '0, "R7", "pointer after flush", vic_ptr, 0);
      chk(vic_present == 1'b0, "R7", "slot 0 cleared", vic_present, 0);
      lookup(20'h2468A, 12'h000, 8'h05, 2'b00, "R7 flushed slot misses");
      lookup(20'h40000, 12'h000, 8'h00, 2'b01, "R7 flushed global misses");
      lookup(20'h66666, 12'h000, 8'h00, 2'b00, "R7 flushed v1 misses");
      // R13: saturation
      for (int k = 0; k < CMAX + 4; k++) lookup(20'h0F0F0, 12'h000, 8'h00, 2'b00, "R13 miss run");
      @(negedge clk);
      check_counters("saturated");
      chk(cnt_rd_miss == CW'(CMAX), "R13", "read miss saturated", cnt_rd_miss, CMAX);
      repeat (2) @(negedge clk);
      chk(sb.size() == 0, "R12", "all results seen", sb.size(), 0);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule